// File: doc/BRIEF.md
# Program Sequencer with Return Stack

This block produces the instruction-memory address for a small 8-bit controller whose instructions take exactly two clock cycles each. A phase flag alternates between fetch and execute. The instruction decoder presents an already-decoded control operation during the execute cycle: advance, jump, call or return, a condition code and a 10-bit target. The sequencer resolves that operation against the carry and zero flags. It loads the resolved address into the program counter on the clock edge that closes the execute cycle.

Calls push the address of the following instruction onto a 16-entry hardware return stack, and returns pop it. An external interrupt request is accepted only at an instruction boundary. When it is accepted, the resolved next address is pushed, control moves to a fixed vector at address 0, and a one-cycle acknowledge pulse is raised. Stack misuse sets sticky flags. A push onto a full stack displaces the oldest entry. A pop from an empty stack sends the program to address 0.

Top module: `prog_seq`

## Requirements
- R1: While the synchronous reset `rst` is high on a clock edge, that edge sets `pc_addr` to 0, `exec_phase` to 0, `irq_ack` to 0, `stk_overflow` and `stk_underflow` to 0, and empties the return stack.
- R2: `exec_phase` toggles on every clock edge out of reset (0 = fetch, 1 = execute). `pc_addr` changes only on the edge that ends an execute cycle. Operation inputs and `irq_req` presented during a fetch cycle have no effect.
- R3: `op_kind` 0 (advance) sets `pc_addr` to `pc_addr + 1` modulo 1024.
- R4: `op_kind` 1 (jump) loads `op_target` when its condition holds. The `op_cond` encoding is: 0 always, 1 zero flag set, 2 zero flag clear, 3 carry flag set, 4 carry flag clear; codes 5 to 7 behave as always.
- R5: A jump or call whose condition does not hold advances `pc_addr` by one and leaves the stack untouched.
- R6: `op_kind` 2 (call), when its condition holds, pushes `pc_addr + 1` and loads `op_target`.
- R7: `op_kind` 3 (return) ignores `op_cond` and loads the most recently pushed address that has not yet been popped (last in, first out).
- R8: A push onto a stack already holding 16 entries discards the oldest entry, keeps the newest 16, and sets `stk_overflow`. The flag stays set until reset.
- R9: A return with an empty stack sets `pc_addr` to 0 and sets `stk_underflow`. The flag stays set until reset.
- R10: An interrupt is accepted when `irq_req` is high at the end of an execute cycle whose `op_kind` is 0 or 1. Acceptance pushes the address that operation would have produced and sets `pc_addr` to 0.
- R11: During an execute cycle with a call or a return, `irq_req` is not accepted. That instruction completes normally, and the request is taken at a later boundary if it is still held.
- R12: `irq_ack` is high for exactly the one cycle that follows the edge at which an interrupt is accepted, and it is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_kind | input | 2 | Decoded operation: 0 advance, 1 jump, 2 call, 3 return |
| op_cond | input | 3 | Condition code for jump and call |
| op_target | input | 10 | Jump or call destination |
| flag_c | input | 1 | Current carry flag |
| flag_z | input | 1 | Current zero flag |
| irq_req | input | 1 | Interrupt request, level sensitive |
| pc_addr | output | 10 | Instruction memory address |
| exec_phase | output | 1 | 0 in fetch cycle, 1 in execute cycle |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| stk_overflow | output | 1 | Sticky: push onto full stack occurred |
| stk_underflow | output | 1 | Sticky: pop from empty stack occurred |

## Verification
An operation presented during an execute cycle takes effect on the very next clock edge. The new address, the acknowledge pulse and both sticky flags are all due one edge after the stimulus. The bench therefore drives each operation on a falling edge and samples every result on the following falling edge, half a period after the edge that produced it. The fetch-cycle edge must leave the address unchanged, so before each execute cycle the bench presents a deliberately different jump and confirms that the address held. The acknowledge is confirmed low one further edge later. The return stack is observed only through the addresses that later returns produce.

// File: rtl/seq_pkg.sv
package seq_pkg;

  // Decoded operation kinds presented by the instruction decoder.
  localparam logic [1:0] OPK_NEXT = 2'd0;
  localparam logic [1:0] OPK_JUMP = 2'd1;
  localparam logic [1:0] OPK_CALL = 2'd2;
  localparam logic [1:0] OPK_RET  = 2'd3;

  // Condition codes for jump and call.
  localparam logic [2:0] CC_ALWAYS = 3'd0;
  localparam logic [2:0] CC_ZSET   = 3'd1;
  localparam logic [2:0] CC_ZCLR   = 3'd2;
  localparam logic [2:0] CC_CSET   = 3'd3;
  localparam logic [2:0] CC_CCLR   = 3'd4;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_e;

  // Condition evaluation; unlisted codes behave as "always".
  function automatic logic cond_holds(input logic [2:0] cc,
                                      input logic      cy,
                                      input logic      zf);
    logic r;
    unique case (cc)
      CC_ZSET: r = zf;
      CC_ZCLR: r = ~zf;
      CC_CSET: r = cy;
      CC_CCLR: r = ~cy;
      default: r = 1'b1;
    endcase
    return r;
  endfunction

  // Operations that touch the stack and therefore block interrupt entry.
  function automatic logic is_stack_op(input logic [1:0] k);
    return (k == OPK_CALL) || (k == OPK_RET);
  endfunction

endpackage

// File: rtl/seq_phase.sv
module seq_phase
  import seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output logic exec_phase,
  output logic boundary
);

  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_FETCH;
    else     phase_q <= (phase_q == PH_FETCH) ? PH_EXEC : PH_FETCH;
  end

  assign exec_phase = (phase_q == PH_EXEC);
  // The edge closing an execute cycle is the instruction boundary.
  assign boundary   = (phase_q == PH_EXEC);

endmodule

// File: rtl/seq_cond.sv
module seq_cond
  import seq_pkg::*;
(
  input  logic [2:0] cc,
  input  logic       cy,
  input  logic       zf,
  output logic       cond_ok
);

  assign cond_ok = cond_holds(cc, cy, zf);

endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
  parameter int W     = 10,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data,
  output logic         empty,
  output logic         full,
  output logic         ovf_evt,
  output logic         unf_evt,
  output logic         ovf_flag,
  output logic         unf_flag
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // Circular index helpers, correct for any depth.
  function automatic logic [PTR_W-1:0] idx_up(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] idx_dn(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST_IDX : p - 1'b1;
  endfunction

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_idx;   // slot the next push writes
  logic [CNT_W-1:0] fill;
  logic [PTR_W-1:0] rd_idx;

  assign rd_idx   = idx_dn(wr_idx);
  assign top_data = slots[rd_idx];
  assign empty    = (fill == '0);
  assign full     = (fill == FULL_CNT);
  assign ovf_evt  = push & full;
  assign unf_evt  = pop & empty;

  // A push onto a full stack writes over the oldest slot: the circular
  // write index already points at it, so only the count saturates.
  always_ff @(posedge clk) begin
    if (push) slots[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      fill   <= '0;
    end else if (push) begin
      wr_idx <= idx_up(wr_idx);
      if (!full) fill <= fill + 1'b1;
    end else if (pop && !empty) begin
      wr_idx <= rd_idx;
      fill   <= fill - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      if (ovf_evt) ovf_flag <= 1'b1;
      if (unf_evt) unf_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import seq_pkg::*;
#(
  parameter int              PC_W        = 10,
  parameter int              STACK_DEPTH = 16,
  parameter logic [PC_W-1:0] IRQ_VECTOR  = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      op_kind,
  input  logic [2:0]      op_cond,
  input  logic [PC_W-1:0] op_target,
  input  logic            flag_c,
  input  logic            flag_z,
  input  logic            irq_req,
  output logic [PC_W-1:0] pc_addr,
  output logic            exec_phase,
  output logic            irq_ack,
  output logic            stk_overflow,
  output logic            stk_underflow
);

  // Sequential address, wrapping at the top of program space.
  function automatic logic [PC_W-1:0] pc_inc(input logic [PC_W-1:0] p);
    return p + 1'b1;
  endfunction

  // Named internal events, visible to the bound checker.
  logic            boundary;
  logic            cond_ok;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] seq_next;
  logic [PC_W-1:0] flow_next;
  logic            call_taken;
  logic            ret_req;
  logic            irq_take;
  logic            push_en;
  logic            pop_en;
  logic [PC_W-1:0] push_data;
  logic [PC_W-1:0] stk_top;
  logic            stk_empty;
  logic            stk_full;
  logic            ovf_evt;
  logic            unf_evt;
  logic            ack_q;

  seq_phase u_phase (
    .clk        (clk),
    .rst        (rst),
    .exec_phase (exec_phase),
    .boundary   (boundary)
  );

  seq_cond u_cond (
    .cc      (op_cond),
    .cy      (flag_c),
    .zf      (flag_z),
    .cond_ok (cond_ok)
  );

  seq_stack #(
    .W     (PC_W),
    .DEPTH (STACK_DEPTH)
  ) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (push_en),
    .pop       (pop_en),
    .push_data (push_data),
    .top_data  (stk_top),
    .empty     (stk_empty),
    .full      (stk_full),
    .ovf_evt   (ovf_evt),
    .unf_evt   (unf_evt),
    .ovf_flag  (stk_overflow),
    .unf_flag  (stk_underflow)
  );

  // Resolve the decoded operation into the address it leads to.
  always_comb begin
    seq_next   = pc_inc(pc_q);
    flow_next  = seq_next;
    call_taken = 1'b0;
    ret_req    = 1'b0;
    unique case (op_kind)
      OPK_JUMP: if (cond_ok) flow_next = op_target;
      OPK_CALL: begin
        if (cond_ok) begin
          flow_next  = op_target;
          call_taken = 1'b1;
        end
      end
      OPK_RET: begin
        ret_req   = 1'b1;
        flow_next = stk_empty ? '0 : stk_top;
      end
      default: flow_next = seq_next;
    endcase
  end

  // Interrupt entry only at a boundary, and never alongside a stack op,
  // so at most one push or pop happens per instruction.
  assign irq_take  = boundary & irq_req & ~is_stack_op(op_kind);
  assign push_en   = boundary & (call_taken | irq_take);
  assign pop_en    = boundary & ret_req;
  assign push_data = irq_take ? flow_next : seq_next;

  always_comb begin
    if (!boundary)     pc_d = pc_q;
    else if (irq_take) pc_d = IRQ_VECTOR;
    else               pc_d = flow_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ack_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      ack_q <= irq_take;
    end
  end

  assign pc_addr = pc_q;
  assign irq_ack = ack_q;

endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int              PC_W   = 10,
  parameter logic [PC_W-1:0] VECTOR = '0
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      op_kind,
  input logic            irq_req,
  input logic [PC_W-1:0] pc_addr,
  input logic            exec_phase,
  input logic            irq_ack,
  input logic            stk_overflow,
  input logic            stk_underflow,
  input logic            cond_ok,
  input logic            push_en,
  input logic            pop_en,
  input logic            stk_empty
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pc_addr == '0) && !exec_phase && !irq_ack && !stk_overflow && !stk_underflow); // R1

  AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> exec_phase != $past(exec_phase)); // R2

  AST_FETCH_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
    !exec_phase |=> pc_addr == $past(pc_addr)); // R2

  AST_NOT_TAKEN_STEP: assert property (@(posedge clk) disable iff (rst)
    exec_phase && (op_kind == 2'd2) && !cond_ok |=> pc_addr == PC_W'($past(pc_addr) + 1'b1)); // R5

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    stk_overflow |=> stk_overflow); // R8

  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    stk_underflow |=> stk_underflow); // R9

  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    pop_en && stk_empty |=> (pc_addr == '0) && stk_underflow); // R9

  AST_ACK_AT_VECTOR: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> pc_addr == VECTOR); // R10

  AST_NO_IRQ_ON_STACK_OP: assert property (@(posedge clk) disable iff (rst)
    exec_phase && op_kind[1] |=> !irq_ack); // R11

  AST_SINGLE_STACK_OP: assert property (@(posedge clk) disable iff (rst)
    push_en |-> !pop_en); // R11

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack); // R12

  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_ack) |-> $past(irq_req) && $past(exec_phase)); // R12

endmodule

bind prog_seq seq_chk #(
  .PC_W   (PC_W),
  .VECTOR (IRQ_VECTOR)
) u_seq_chk (
  .clk           (clk),
  .rst           (rst),
  .op_kind       (op_kind),
  .irq_req       (irq_req),
  .pc_addr       (pc_addr),
  .exec_phase    (exec_phase),
  .irq_ack       (irq_ack),
  .stk_overflow  (stk_overflow),
  .stk_underflow (stk_underflow),
  .cond_ok       (cond_ok),
  .push_en       (push_en),
  .pop_en        (pop_en),
  .stk_empty     (stk_empty)
);

// File: tb/prog_seq_test.sv
`timescale 1ns/1ps
module prog_seq_test;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op_kind = '0;
  logic [2:0] op_cond = '0;
  logic [9:0] op_target = '0;
  logic       flag_c = 1'b0;
  logic       flag_z = 1'b0;
  logic       irq_req = 1'b0;
  logic [9:0] pc_addr;
  logic       exec_phase;
  logic       irq_ack;
  logic       stk_overflow;
  logic       stk_underflow;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Reference state
  int m_pc;
  int m_stk [DEPTH];
  int m_cnt;
  bit m_ovf, m_unf;

  always #2.5 clk = ~clk;

  prog_seq #(.PC_W(10), .STACK_DEPTH(DEPTH), .IRQ_VECTOR(10'd0)) uut (
    .clk(clk), .rst(rst), .op_kind(op_kind), .op_cond(op_cond),
    .op_target(op_target), .flag_c(flag_c), .flag_z(flag_z),
    .irq_req(irq_req), .pc_addr(pc_addr), .exec_phase(exec_phase),
    .irq_ack(irq_ack), .stk_overflow(stk_overflow),
    .stk_underflow(stk_underflow)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit m_taken(input int cc, input bit c, input bit z);
    if (cc == 1) return z;
    if (cc == 2) return !z;
    if (cc == 3) return c;
    if (cc == 4) return !c;
    return 1'b1;
  endfunction

  // Shift-register reference for the stack: the oldest entry sits at index 0.
  task automatic m_push(input int v);
    if (m_cnt == DEPTH) begin
      for (int i = 0; i < DEPTH - 1; i++) m_stk[i] = m_stk[i+1];
      m_stk[DEPTH-1] = v;
      m_ovf = 1'b1;
    end else begin
      m_stk[m_cnt] = v;
      m_cnt++;
    end
  endtask

  task automatic m_pop(output int v);
    if (m_cnt == 0) begin
      m_unf = 1'b1;
      v = 0;
    end else begin
      m_cnt--;
      v = m_stk[m_cnt];
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    op_kind = '0; op_cond = '0; op_target = '0; irq_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_pc = 0; m_cnt = 0; m_ovf = 1'b0; m_unf = 1'b0;
    chk("R1", "pc after reset", int'(pc_addr), 0);
    chk("R1", "phase after reset", int'(exec_phase), 0);
    chk("R1", "ack after reset", int'(irq_ack), 0);
    chk("R1", "overflow after reset", int'(stk_overflow), 0);
    chk("R1", "underflow after reset", int'(stk_underflow), 0);
  endtask

  // One instruction: fetch cycle with decoy inputs, then execute cycle.
  task automatic run(input int op, input int cc, input int tgt, input bit c,
                     input bit z, input bit irq, input string tag);
    int nxt, flow;
    bit irqt;
    chk("R2", "phase at fetch", int'(exec_phase), 0);
    chk("R2", "pc at fetch", int'(pc_addr), m_pc);
    op_kind = 2'd1; op_cond = 3'd0; op_target = 10'(~m_pc);
    flag_c = c; flag_z = z; irq_req = 1'b1;
    @(negedge clk);
    chk("R2", "phase at execute", int'(exec_phase), 1);
    chk("R2", "pc held over fetch edge", int'(pc_addr), m_pc);
    chk("R12", "ack low after pulse", int'(irq_ack), 0);
    op_kind = 2'(op); op_cond = 3'(cc); op_target = 10'(tgt); irq_req = irq;
    nxt  = (m_pc + 1) % 1024;
    irqt = irq && (op < 2);
    flow = nxt;
    case (op)
      1: if (m_taken(cc, c, z)) flow = tgt;
      2: if (m_taken(cc, c, z)) begin flow = tgt; m_push(nxt); end
      3: m_pop(flow);
      default: flow = nxt;
    endcase
    if (irqt) begin m_push(flow); m_pc = 0; end
    else m_pc = flow;
    @(negedge clk);
    irq_req = 1'b0;
    chk(tag, "pc after execute", int'(pc_addr), m_pc);
    chk("R12", "ack after execute", int'(irq_ack), int'(irqt));
    chk("R8", "overflow flag", int'(stk_overflow), int'(m_ovf));
    chk("R9", "underflow flag", int'(stk_underflow), int'(m_unf));
  endtask

  initial begin
    do_reset();
    // R9: return on an empty stack right after reset
    run(3, 0, 0, 0, 0, 0, "R9");

    // Sweep every operation, condition code and flag pair.
    do_reset();
    for (int op = 0; op < 4; op++)
      for (int cc = 0; cc < 8; cc++)
        for (int f = 0; f < 4; f++) begin
          bit c = f[0];
          bit z = f[1];
          int tgt = (op * 311 + cc * 53 + f * 17 + 9) % 1024;
          string tag;
          if (op == 0)      tag = "R3";
          else if (op == 3) tag = "R7";
          else if (!m_taken(cc, c, z)) tag = "R5";
          else if (op == 1) tag = "R4";
          else              tag = "R6";
          run(op, cc, tgt, c, z, 0, tag);
        end

    // R3: wrap from the top of program space
    do_reset();
    run(1, 0, 1023, 0, 0, 0, "R4");
    run(0, 0, 0, 0, 0, 0, "R3");

    // Deep nesting: 20 calls overflow, 21 returns reach underflow.
    do_reset();
    for (int k = 0; k < 20; k++) run(2, 0, (k * 50 + 7) % 1024, 0, 0, 0, "R6");
    for (int k = 0; k < 21; k++) run(3, 5, 0, 1, 1, 0, (k < 16) ? "R7" : "R9");
    chk("R8", "overflow remains set", int'(stk_overflow), 1);

    // Interrupt entry and deferral.
    do_reset();
    run(1, 0, 100, 0, 0, 0, "R4");
    run(0, 0, 0, 0, 0, 1, "R10");
    run(1, 0, 600, 0, 0, 0, "R4");
    run(1, 1, 200, 0, 1, 1, "R10");
    run(1, 0, 700, 0, 0, 0, "R4");
    run(1, 3, 250, 0, 0, 1, "R10");
    run(2, 0, 300, 0, 0, 1, "R11");
    run(3, 0, 0, 0, 0, 1, "R11");
    run(3, 0, 0, 0, 0, 0, "R10");
    run(3, 0, 0, 0, 0, 0, "R10");
    run(3, 0, 0, 0, 0, 0, "R10");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule